// File: doc/BRIEF.md
# Four-Voice Addressed Tone Mixer

This block is the digital front end of a small tone synthesiser. It holds four independent voices. Each voice keeps a note code, an octave code and a loudness code, and from them it makes a square wave with a 50 % duty cycle. All voices are loaded through one shared input bus. A two-bit channel address on that bus picks the voice that a write strobe updates, so a write changes only that voice.

Every clock cycle the mixer adds up the four voices. A voice adds its loudness weight while its square wave is high and nothing while the wave is low. The sum leaves the block as a registered five-bit code. An external converter scales that code by one quarter and filters it into a sum of sine tones.

The write strobe has a two-state machine: `WS_IDLE` (armed) and `WS_HELD` (a write was taken and the strobe is still high). The transition `WS_IDLE -> WS_HELD` happens when the strobe is sampled high, and that same edge performs the write. The transition `WS_HELD -> WS_IDLE` happens when the strobe is sampled low. Each voice has a two-state machine: `V_MUTE` (silent, wave held low) and `V_RUN` (dividing the clock). The transition `V_MUTE -> V_RUN` happens when a write loads an audible setting. The transition `V_RUN -> V_MUTE` happens when a write loads a silent one. A write to a voice in `V_RUN` that loads another audible setting keeps the state and restarts the wave.

Top module: `four_voice_mixer`

## Requirements
- R1: `chan_sel` value 0, 1, 2 or 3 steers an accepted write to voice 1, 2, 3 or 4 respectively; no other voice changes its setting or its wave phase.
- R2: A write is accepted on the first rising edge at which `wr_stb` is sampled high; while `wr_stb` stays high, no further write is taken, whatever the bus carries. `wr_stb` must be sampled low at least once before the next write.
- R3: In the top octave, note code c (0 = B, 1 = A#, 2 = A, 3 = G#, 4 = G, 5 = F#, 6 = F, 7 = E, 8 = D#, 9 = D, 10 = C#, 11 = C) has a half period of round(60000 / f) clock cycles, with f = 987.767 * 2^(-c/12) Hz. For c from 0 to 11 this gives 61, 64, 68, 72, 77, 81, 86, 91, 96, 102, 108 and 115 cycles.
- R4: A write restarts the voice with its wave low. The wave first rises exactly H*S clock edges after the write edge and then toggles every H*S edges, where H is the half period from R3 and S is the octave scale. The octave code sets S: code 0 = 1 (top octave), code 1 = 2 (middle octave), code 2 = 4 (low octave). Octave code 3 silences the voice.
- R5: Loudness code 1, 2 or 3 gives the voice a weight of 1, 2 or 4 LSB while its wave is high. Loudness code 0 silences the voice.
- R6: Note codes 12 to 15 silence the voice.
- R7: `mix_code` is the sum of the four voice contributions. It is registered, so it changes one clock edge after the voice waves change, and it stays within 0 to 16.
- R8: Reset silences all four voices and drives `mix_code` to 0, and it stays 0 until a voice is loaded with an audible setting.
- R9: All four voices sound at the same time, each with its own note, octave and loudness.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write strobe for the shared bus |
| chan_sel | input | 2 | Voice address for the write |
| note_code | input | 4 | Note code (R3, R6) |
| oct_code | input | 2 | Octave code (R4) |
| lvl_code | input | 2 | Loudness code (R5) |
| mix_code | output | 5 | Registered sum of the voice contributions |

## Verification
A write to one voice can land on the same clock edge as a wave toggle of another voice. The mix register must then show both effects together: the loaded voice returns to low, and the toggled voice takes its new level. The bench provokes this by rewriting and muting voices while the other voices are sounding, and by holding the strobe high while the address and codes change under it. An independent cycle model of every voice, built from the write edge and the R3/R4 timing, predicts `mix_code` at every cycle, so a lost, repeated or misrouted write shows up as a mismatch in the cycle where it happens.

// File: rtl/tone_mix_pkg.sv
package tone_mix_pkg;

    // width of a half-period count in top-octave clock cycles
    localparam int NOTE_HALF_W = 7;
    // width of the octave prescale counter (scales 1, 2, 4)
    localparam int PRE_W       = 2;
    // width of one voice's weighted contribution (0, 1, 2, 4)
    localparam int LEVEL_W     = 3;
    // number of note codes with a defined pitch
    localparam int NUM_NOTES   = 12;

    typedef enum logic [1:0] {
        LVL_OFF  = 2'b00,
        LVL_SOFT = 2'b01,
        LVL_MID  = 2'b10,
        LVL_LOUD = 2'b11
    } level_e;

    typedef enum logic [1:0] {
        OCT_UP     = 2'b00,
        OCT_CENTRE = 2'b01,
        OCT_DOWN   = 2'b10,
        OCT_NONE   = 2'b11
    } octave_e;

    typedef struct packed {
        logic [3:0] note;
        octave_e    oct;
        level_e     lvl;
    } voice_cfg_t;

    // half period in clock cycles for the top octave; 0 marks an undefined code
    function automatic logic [NOTE_HALF_W-1:0] note_half(input logic [3:0] code);
        logic [NOTE_HALF_W-1:0] h;
        unique case (code)
            4'd0:    h = NOTE_HALF_W'(61);
            4'd1:    h = NOTE_HALF_W'(64);
            4'd2:    h = NOTE_HALF_W'(68);
            4'd3:    h = NOTE_HALF_W'(72);
            4'd4:    h = NOTE_HALF_W'(77);
            4'd5:    h = NOTE_HALF_W'(81);
            4'd6:    h = NOTE_HALF_W'(86);
            4'd7:    h = NOTE_HALF_W'(91);
            4'd8:    h = NOTE_HALF_W'(96);
            4'd9:    h = NOTE_HALF_W'(102);
            4'd10:   h = NOTE_HALF_W'(108);
            4'd11:   h = NOTE_HALF_W'(115);
            default: h = '0;
        endcase
        return h;
    endfunction

    // last value of the prescale counter for each octave
    function automatic logic [PRE_W-1:0] octave_last(input octave_e o);
        logic [PRE_W-1:0] p;
        unique case (o)
            OCT_UP:     p = PRE_W'(0);
            OCT_CENTRE: p = PRE_W'(1);
            OCT_DOWN:   p = PRE_W'(3);
            default:    p = PRE_W'(0);
        endcase
        return p;
    endfunction

    function automatic logic [LEVEL_W-1:0] level_weight(input level_e l);
        logic [LEVEL_W-1:0] w;
        unique case (l)
            LVL_SOFT: w = LEVEL_W'(1);
            LVL_MID:  w = LEVEL_W'(2);
            LVL_LOUD: w = LEVEL_W'(4);
            default:  w = '0;
        endcase
        return w;
    endfunction

    function automatic logic cfg_audible(input voice_cfg_t c);
        return (c.lvl != LVL_OFF) && (c.oct != OCT_NONE) && (c.note < 4'(NUM_NOTES));
    endfunction

endpackage

// File: rtl/write_steer.sv
module write_steer #(
    parameter  int NUM_VOICES = 4,
    localparam int SEL_W      = $clog2(NUM_VOICES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [SEL_W-1:0]      sel_i,
    output logic [NUM_VOICES-1:0] wen_o
);

    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_HELD = 1'b1
    } steer_state_e;

    steer_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE: if (wr_i)  state_d = WS_HELD;
            WS_HELD: if (!wr_i) state_d = WS_IDLE;
            default: state_d = WS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    // outputs: one write enable, only on the edge that leaves WS_IDLE
    always_comb begin
        wen_o = '0;
        unique case (state_q)
            WS_IDLE: begin
                for (int v = 0; v < NUM_VOICES; v++) begin
                    if (wr_i && (sel_i == SEL_W'(v))) wen_o[v] = 1'b1;
                end
            end
            WS_HELD: wen_o = '0;
            default: wen_o = '0;
        endcase
    end

    // R1
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wen_o));

    // R2
    no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_o != '0) |=> (wen_o == '0));

endmodule

// File: rtl/tone_voice.sv
module tone_voice
    import tone_mix_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  voice_cfg_t         cfg_i,
    output logic [LEVEL_W-1:0] level_o
);

    typedef enum logic {
        V_MUTE = 1'b0,
        V_RUN  = 1'b1
    } voice_state_e;

    voice_state_e           state_q, state_d;
    voice_cfg_t             cfg_q;
    logic [PRE_W-1:0]       pre_q;
    logic [NOTE_HALF_W-1:0] div_q;
    logic                   wave_q;
    logic [PRE_W-1:0]       pre_last;
    logic [NOTE_HALF_W-1:0] half_last;
    logic                   tick;

    assign pre_last  = octave_last(cfg_q.oct);
    assign half_last = note_half(cfg_q.note) - NOTE_HALF_W'(1);
    assign tick      = (pre_q == pre_last);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            V_MUTE:  if (load_i && cfg_audible(cfg_i))  state_d = V_RUN;
            V_RUN:   if (load_i && !cfg_audible(cfg_i)) state_d = V_MUTE;
            default: state_d = V_MUTE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= V_MUTE;
        else        state_q <= state_d;
    end

    // setting store, prescaler and half-period divider
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            pre_q  <= '0;
            div_q  <= '0;
            wave_q <= 1'b0;
        end else if (load_i) begin
            cfg_q  <= cfg_i;
            pre_q  <= '0;
            div_q  <= '0;
            wave_q <= 1'b0;
        end else if (state_q == V_RUN) begin
            if (tick) begin
                pre_q <= '0;
                if (div_q == half_last) begin
                    div_q  <= '0;
                    wave_q <= ~wave_q;
                end else begin
                    div_q <= div_q + NOTE_HALF_W'(1);
                end
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        level_o = '0;
        unique case (state_q)
            V_RUN:   if (wave_q) level_o = level_weight(cfg_q.lvl);
            V_MUTE:  level_o = '0;
            default: level_o = '0;
        endcase
    end

    // R4
    wave_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(wave_q) && !$past(load_i)) |->
            ($past(tick) && ($past(div_q) == $past(half_last))));

    // R5
    mute_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == V_MUTE) |-> (wave_q == 1'b0));

endmodule

// File: rtl/level_mixer.sv
module level_mixer
    import tone_mix_pkg::*;
#(
    parameter  int NUM_VOICES = 4,
    localparam int MAX_MIX    = NUM_VOICES * (1 << (LEVEL_W - 1)),
    localparam int MIX_W      = $clog2(MAX_MIX + 1)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_VOICES-1:0][LEVEL_W-1:0]  levels_i,
    output logic [MIX_W-1:0]                    mix_o
);

    logic [MIX_W-1:0] sum_d;

    always_comb begin
        sum_d = '0;
        for (int v = 0; v < NUM_VOICES; v++) begin
            sum_d = sum_d + MIX_W'(levels_i[v]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mix_o <= '0;
        else        mix_o <= sum_d;
    end

    // R7
    mix_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mix_o <= MIX_W'(MAX_MIX));

endmodule

// File: rtl/four_voice_mixer.sv
module four_voice_mixer
    import tone_mix_pkg::*;
#(
    parameter  int NUM_VOICES = 4,
    localparam int CH_W       = $clog2(NUM_VOICES),
    localparam int MIX_W      = $clog2(NUM_VOICES * (1 << (LEVEL_W - 1)) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [CH_W-1:0]  chan_sel,
    input  logic [3:0]       note_code,
    input  logic [1:0]       oct_code,
    input  logic [1:0]       lvl_code,
    output logic [MIX_W-1:0] mix_code
);

    logic [NUM_VOICES-1:0]              voice_wen;
    logic [NUM_VOICES-1:0][LEVEL_W-1:0] voice_lvl;
    voice_cfg_t                         bus_cfg;

    assign bus_cfg.note = note_code;
    assign bus_cfg.oct  = octave_e'(oct_code);
    assign bus_cfg.lvl  = level_e'(lvl_code);

    write_steer #(
        .NUM_VOICES(NUM_VOICES)
    ) u_steer (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (wr_stb),
        .sel_i (chan_sel),
        .wen_o (voice_wen)
    );

    for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
        tone_voice u_voice (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (voice_wen[v]),
            .cfg_i   (bus_cfg),
            .level_o (voice_lvl[v])
        );
    end

    level_mixer #(
        .NUM_VOICES(NUM_VOICES)
    ) u_mix (
        .clk      (clk),
        .rst_n    (rst_n),
        .levels_i (voice_lvl),
        .mix_o    (mix_code)
    );

endmodule

// File: tb/test_four_voice_mixer.sv
module test_four_voice_mixer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_stb;
    logic [1:0] chan_sel;
    logic [3:0] note_code;
    logic [1:0] oct_code;
    logic [1:0] lvl_code;
    logic [4:0] mix_code;

    always #5 clk = ~clk;

    four_voice_mixer i_four_voice_mixer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .chan_sel  (chan_sel),
        .note_code (note_code),
        .oct_code  (oct_code),
        .lvl_code  (lvl_code),
        .mix_code  (mix_code)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    int peak  = 0;

    // model of each voice: write edge, full half period (H*S), weight
    int m_t0 [4];
    int m_hp [4];
    int m_w  [4];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int half_of(input int code);
        real f;
        if (code > 11) return 0;
        f = 987.767 * (2.0 ** (-code / 12.0));
        return $rtoi(60000.0 / f + 0.5);
    endfunction

    function automatic int scale_of(input int oct);
        if (oct == 0) return 1;
        if (oct == 1) return 2;
        if (oct == 2) return 4;
        return 0;
    endfunction

    function automatic int weight_of(input int lv);
        if (lv == 1) return 1;
        if (lv == 2) return 2;
        if (lv == 3) return 4;
        return 0;
    endfunction

    function automatic int model_mix();
        int s;
        s = 0;
        for (int v = 0; v < 4; v++) begin
            int m;
            m = cyc - m_t0[v];
            if (m_w[v] != 0 && m_hp[v] != 0 && m >= 1) begin
                if (((m - 1) / m_hp[v]) % 2 == 1) s += m_w[v];
            end
        end
        return s;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: mix_code=%0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic model_clear();
        for (int v = 0; v < 4; v++) begin
            m_t0[v] = 0;
            m_hp[v] = 0;
            m_w[v]  = 0;
        end
    endtask

    task automatic model_load(input int ch, input int nt, input int oc, input int lv);
        m_t0[ch] = cyc + 1;
        m_hp[ch] = half_of(nt) * scale_of(oc);
        m_w[ch]  = (m_hp[ch] != 0) ? weight_of(lv) : 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        wr_stb   = 1'b0;
        chan_sel = '0;
        note_code = '0;
        oct_code = '0;
        lvl_code = '0;
        repeat (3) @(negedge clk);
        model_clear();
        rst_n = 1'b1;
    endtask

    task automatic write_voice(input int ch, input int nt, input int oc, input int lv);
        @(negedge clk);
        wr_stb    = 1'b1;
        chan_sel  = 2'(ch);
        note_code = 4'(nt);
        oct_code  = 2'(oc);
        lvl_code  = 2'(lv);
        model_load(ch, nt, oc, lv);
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic run_compare(input string req, input int ncyc);
        peak = 0;
        repeat (ncyc) begin
            @(negedge clk);
            if (int'(mix_code) > peak) peak = int'(mix_code);
            check(req, int'(mix_code), model_mix());
        end
    endtask

    // R8: reset state, also after voices were sounding
    task automatic t_reset();
        do_reset();
        check("R8", int'(mix_code), 0);
        write_voice(0, 2, 0, 3);
        write_voice(1, 0, 0, 2);
        run_compare("R9", 150);
        do_reset();
        check("R8", int'(mix_code), 0);
        run_compare("R8", 300);
    endtask

    // R3/R4: one voice in the top octave, exact rise and fall edges
    task automatic t_single_top();
        do_reset();
        write_voice(0, 2, 0, 3);
        run_compare("R3", 420);
        write_voice(0, 11, 0, 1);
        run_compare("R3", 500);
        write_voice(0, 0, 0, 2);
        run_compare("R4", 300);
    endtask

    // R4: octave scales 2 and 4
    task automatic t_octaves();
        do_reset();
        write_voice(1, 11, 1, 2);
        run_compare("R4", 700);
        write_voice(1, 0, 2, 1);
        run_compare("R4", 800);
    endtask

    // R1/R5: address isolation and muting by loudness code 0
    task automatic t_address();
        do_reset();
        write_voice(2, 7, 0, 3);
        write_voice(3, 0, 2, 1);
        run_compare("R1", 800);
        write_voice(2, 7, 0, 0);
        run_compare("R5", 600);
        write_voice(1, 4, 1, 2);
        run_compare("R1", 600);
    endtask

    // R2: strobe held high while the bus changes
    task automatic t_hold();
        do_reset();
        @(negedge clk);
        wr_stb    = 1'b1;
        chan_sel  = 2'd0;
        note_code = 4'd2;
        oct_code  = 2'd0;
        lvl_code  = 2'd2;
        model_load(0, 2, 0, 2);
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            chan_sel  = 2'(k % 4);
            note_code = 4'(k % 12);
            lvl_code  = 2'd3;
            check("R2", int'(mix_code), model_mix());
        end
        wr_stb = 1'b0;
        run_compare("R2", 300);
        write_voice(0, 9, 0, 3);
        run_compare("R2", 300);
    endtask

    // R6/R4/R5: undefined codes stay silent
    task automatic t_silent_codes();
        do_reset();
        write_voice(0, 12, 0, 3);
        write_voice(1, 15, 1, 3);
        write_voice(2, 2, 3, 3);
        write_voice(3, 2, 0, 0);
        run_compare("R6", 400);
        check("R6", peak, 0);
    endtask

    // R7: all four voices loud on one note reach the top of the range
    task automatic t_full_mix();
        do_reset();
        for (int v = 0; v < 4; v++) write_voice(v, 0, 0, 3);
        run_compare("R7", 250);
        check("R7", peak, 16);
    endtask

    // R9: four different voices together, rewrites during play
    task automatic t_mixed();
        do_reset();
        write_voice(0, 2, 0, 1);
        write_voice(1, 5, 1, 2);
        write_voice(2, 11, 2, 3);
        write_voice(3, 8, 0, 2);
        run_compare("R9", 1500);
        write_voice(1, 1, 0, 3);
        run_compare("R9", 900);
    endtask

    initial begin
        rst_n     = 1'b0;
        wr_stb    = 1'b0;
        chan_sel  = '0;
        note_code = '0;
        oct_code  = '0;
        lvl_code  = '0;
        model_clear();
        t_reset();
        t_single_top();
        t_octaves();
        t_address();
        t_hold();
        t_silent_codes();
        t_full_mix();
        t_mixed();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(150000 * 10);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not end, cycle=%0d expected completion", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule